// File: doc/BRIEF.md
# Fixed Off-Time Mixed-Decay Chopper

This block limits the peak current of an H-bridge drive by enforcing a fixed off-time whenever the current comparator trips. The comparator is delivered as one digital bit, `trip_i`. It is high when the sense voltage, amplified tenfold, is above the reference. While the external drive command is active and no brake is in progress, an accepted trip starts an off-time. That off-time opens with a dead-time gap, continues with a short fast-decay part and ends with a slow-decay part. Fast decay lasts 13 percent of the programmed off-time, rounded down and never less than one cycle. Slow decay covers the rest of the programmed time.

The block blanks the comparator after every switching transition, so that recovery spikes cannot start a false chop. Three transitions open a blanking window: the end of an off-time, the drive command becoming active, and the release of a brake. A brake suppresses all chopping, because brake current does not pass through the sense resistor. Dropping the drive command in the middle of an off-time cancels the chop at once, and external decay control takes over.

The controller has six states. `CS_IDLE` means the drive is off or braking. `CS_BLANK` counts out the blanking window. `CS_ARMED` waits for a trip. `CS_DEAD`, `CS_FAST` and `CS_SLOW` make up the off-time. The transitions are:
- IDLE to BLANK when the drive is on and there is no brake.
- BLANK to ARMED when the window expires.
- ARMED to DEAD on a trip.
- DEAD to FAST, then FAST to SLOW, each when its count expires.
- SLOW to BLANK when the off-time ends.
- Any state to IDLE when the drive drops or the brake asserts.

Top module: `offtime_chopper`

## Requirements
- R1: While reset is held, and after it with the drive off, `chop_o`, `fast_o` and `limit_o` are all 0.
- R2: After the drive becomes active, the comparator is ignored for BLANK_CYCLES cycles. A trip that is held high from that point is first accepted at the clock edge BLANK_CYCLES+1 cycles after the first edge that sees the drive active.
- R3: An accepted trip raises `chop_o` in the cycle after the accepting edge. It stays high for exactly DEAD_CYCLES + OFF_CYCLES consecutive cycles.
- R4: Within the off-time, `fast_o` (1 = fast decay, 0 = slow decay) is 0 for the first DEAD_CYCLES cycles. It is then 1 for max(1, floor(OFF_CYCLES*13/100)) cycles, and 0 for the remaining cycles. `fast_o` is never 1 outside an off-time.
- R5: `limit_o` is high for exactly one cycle, which is the first cycle of each off-time.
- R6: After an off-time ends, `chop_o` stays 0 for BLANK_CYCLES cycles plus one armed cycle, even with the trip held. With the trip low, no new off-time starts.
- R7: When the drive command goes low during an off-time, `chop_o` and `fast_o` are 0 from the next cycle.
- R8: When the drive returns high, or a brake is released, a fresh blanking window runs before any trip is accepted.
- R9: While `brake_i` is high, no off-time starts and `chop_o` stays 0, whatever the value of the comparator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trip_i | input | 1 | Comparator bit: high when ten times the sense voltage exceeds the reference |
| drive_on_i | input | 1 | External drive command (enable level); its edges are external chop transitions |
| brake_i | input | 1 | Brake in progress; disables chopping |
| chop_o | output | 1 | High while an internal off-time is running |
| fast_o | output | 1 | Decay select during the off-time: 1 fast, 0 slow |
| limit_o | output | 1 | One-cycle pulse when a trip is accepted |

## Verification
All outputs are decoded from state, so each result appears in the cycle that follows the clock edge that caused it. A trip sampled in the armed state at edge k gives `chop_o` and `limit_o` in cycle k+1. A drive rise seen at edge k gives armed state at k+BLANK_CYCLES and acceptance at the next edge. The driver works out the absolute cycle of each expected output from these counts and queues it in order. The monitor samples on the falling edge and compares only the entries whose cycle number matches the current one. A result that comes one cycle early or late is therefore reported as a mismatch.

// File: rtl/chop_pkg.sv
package chop_pkg;

    typedef enum logic [2:0] {
        CS_IDLE  = 3'd0,
        CS_BLANK = 3'd1,
        CS_ARMED = 3'd2,
        CS_DEAD  = 3'd3,
        CS_FAST  = 3'd4,
        CS_SLOW  = 3'd5
    } chop_state_e;

    // Fast-decay share of the programmed off-time: 13 %, floor, at least 1.
    function automatic int fast_len(input int off_cycles);
        int raw;
        raw = (off_cycles * 13) / 100;
        return (raw < 1) ? 1 : raw;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/chop_timer.sv
module chop_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    // R3: the count only falls when not reloaded
    timer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !expired) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/offtime_chopper.sv
module offtime_chopper
    import chop_pkg::*;
#(
    parameter int OFF_CYCLES   = 40,
    parameter int DEAD_CYCLES  = 2,
    parameter int BLANK_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trip_i,
    input  logic drive_on_i,
    input  logic brake_i,
    output logic chop_o,
    output logic fast_o,
    output logic limit_o
);
    localparam int FAST_CYCLES = fast_len(OFF_CYCLES);
    localparam int SLOW_CYCLES = OFF_CYCLES - FAST_CYCLES;
    localparam int MAX_LEN     = max3(BLANK_CYCLES, DEAD_CYCLES,
                                      max3(FAST_CYCLES, SLOW_CYCLES, 1));
    localparam int CW          = $clog2(MAX_LEN + 1);

    localparam logic [CW-1:0] LD_BLANK = CW'(BLANK_CYCLES - 1);
    localparam logic [CW-1:0] LD_DEAD  = CW'(DEAD_CYCLES - 1);
    localparam logic [CW-1:0] LD_FAST  = CW'(FAST_CYCLES - 1);
    localparam logic [CW-1:0] LD_SLOW  = CW'(SLOW_CYCLES - 1);

    chop_state_e   state_q, state_d;
    logic          expired;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          lim_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!drive_on_i || brake_i) begin
            state_d = CS_IDLE;
        end else begin
            unique case (state_q)
                CS_IDLE:  state_d = CS_BLANK;
                CS_BLANK: if (expired) state_d = CS_ARMED;
                CS_ARMED: if (trip_i)  state_d = CS_DEAD;
                CS_DEAD:  if (expired) state_d = CS_FAST;
                CS_FAST:  if (expired) state_d = CS_SLOW;
                CS_SLOW:  if (expired) state_d = CS_BLANK;
                default:  state_d = CS_IDLE;
            endcase
        end
    end

    // Timer reload on every state entry
    always_comb begin
        tmr_load = (state_d != state_q);
        unique case (state_d)
            CS_BLANK: tmr_val = LD_BLANK;
            CS_DEAD:  tmr_val = LD_DEAD;
            CS_FAST:  tmr_val = LD_FAST;
            CS_SLOW:  tmr_val = LD_SLOW;
            default:  tmr_val = '0;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CS_IDLE;
            lim_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            lim_q   <= (state_q == CS_ARMED) && (state_d == CS_DEAD);
        end
    end

    chop_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (expired)
    );

    // Outputs
    always_comb begin
        chop_o  = 1'b0;
        fast_o  = 1'b0;
        limit_o = lim_q;
        unique case (state_q)
            CS_DEAD: chop_o = 1'b1;
            CS_FAST: begin
                chop_o = 1'b1;
                fast_o = 1'b1;
            end
            CS_SLOW: chop_o = 1'b1;
            default: ;
        endcase
    end

    // R7
    drive_off_cancels_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_on_i |=> (!chop_o && !fast_o));

    // R9
    brake_blocks_chop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brake_i |=> !chop_o);

    // R5
    limit_on_chop_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        limit_o |-> $rose(chop_o));

    // R4
    fast_after_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fast_o) |-> ($past(chop_o) && !$past(fast_o)));

    // R6
    gap_after_chop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(chop_o) |=> !chop_o);

endmodule

// File: tb/tb_offtime_chopper.sv
module tb_offtime_chopper;
    localparam int CLK_PERIOD = 10;
    localparam int OFF   = 40;
    localparam int DEAD  = 2;
    localparam int BLANK = 4;
    localparam int FAST_RAW = (OFF * 13) / 100;
    localparam int FAST_EXP = (FAST_RAW < 1) ? 1 : FAST_RAW;

    logic clk = 1'b0;
    logic rst_n, trip_i, drive_on_i, brake_i;
    logic chop_o, fast_o, limit_o;

    typedef struct {
        int    cyc;
        bit    chop;
        bit    fast;
        bit    lim;
        string tag;
    } exp_t;

    exp_t q[$];
    exp_t e_m;
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    offtime_chopper #(.OFF_CYCLES(OFF), .DEAD_CYCLES(DEAD), .BLANK_CYCLES(BLANK)) dut (
        .clk(clk), .rst_n(rst_n), .trip_i(trip_i), .drive_on_i(drive_on_i),
        .brake_i(brake_i), .chop_o(chop_o), .fast_o(fast_o), .limit_o(limit_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    // Monitor: pops and compares entries due in the current cycle
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].cyc <= cyc) begin
            e_m = q.pop_front();
            checks++;
            if (e_m.cyc != cyc || chop_o !== e_m.chop || fast_o !== e_m.fast
                || limit_o !== e_m.lim) begin
                errors++;
                $display("FAIL %s cyc=%0d actual chop=%0b fast=%0b lim=%0b expected chop=%0b fast=%0b lim=%0b",
                         e_m.tag, cyc, chop_o, fast_o, limit_o, e_m.chop, e_m.fast, e_m.lim);
            end
        end
    end

    task automatic push(input int c, input bit ch, input bit fa, input bit li, input string tag);
        exp_t e;
        e.cyc = c; e.chop = ch; e.fast = fa; e.lim = li; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic push_quiet(input int from, input int to, input string tag);
        for (int i = from; i <= to; i++) push(i, 1'b0, 1'b0, 1'b0, tag);
    endtask

    // Full off-time starting at cycle t, then blank window and armed cycle
    task automatic push_chop(input int t);
        for (int i = 0; i < DEAD; i++) push(t + i, 1'b1, 1'b0, (i == 0), (i == 0) ? "R5" : "R3");
        for (int i = 0; i < OFF; i++)
            push(t + DEAD + i, 1'b1, (i < FAST_EXP), 1'b0, "R4");
        push_quiet(t + DEAD + OFF, t + DEAD + OFF + BLANK, "R6");
    endtask

    task automatic go_to(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    initial begin
        int c, t0, t1, c2;
        rst_n = 1'b0; trip_i = 1'b0; drive_on_i = 1'b0; brake_i = 1'b0;
        repeat (3) @(negedge clk);
        checks++;
        if (chop_o !== 1'b0 || fast_o !== 1'b0 || limit_o !== 1'b0) begin
            errors++;
            $display("FAIL R1 in reset actual %0b%0b%0b expected 000", chop_o, fast_o, limit_o);
        end
        rst_n = 1'b1;
        push_quiet(1, 1, "R1");

        // Drive on with trip held: blanking, two chained off-times
        go_to(2);
        c = cyc;
        drive_on_i = 1'b1; trip_i = 1'b1;
        push_quiet(c + 1, c + BLANK + 1, "R2");
        t0 = c + BLANK + 2;
        push_chop(t0);
        t1 = t0 + DEAD + OFF + BLANK + 1;
        push_chop(t1);
        go_to(t1 + DEAD + OFF - 1);
        trip_i = 1'b0;
        push_quiet(t1 + DEAD + OFF + BLANK + 1, t1 + DEAD + OFF + BLANK + 3, "R6");
        go_to(t1 + DEAD + OFF + BLANK + 3);

        // Drive drop cancels an off-time; re-enable re-blanks
        c = cyc;
        trip_i = 1'b1;
        for (int i = 0; i < DEAD; i++) push(c + 1 + i, 1'b1, 1'b0, (i == 0), "R5");
        push(c + DEAD + 1, 1'b1, 1'b1, 1'b0, "R4");
        push(c + DEAD + 2, 1'b1, 1'b1, 1'b0, "R4");
        go_to(c + DEAD + 2);
        drive_on_i = 1'b0;
        push_quiet(c + DEAD + 3, c + DEAD + 6, "R7");
        go_to(c + DEAD + 6);
        c2 = cyc;
        drive_on_i = 1'b1;
        push_quiet(c2 + 1, c2 + BLANK + 1, "R8");
        push_chop(c2 + BLANK + 2);
        go_to(c2 + BLANK + 2 + DEAD + OFF - 1);
        trip_i = 1'b0;
        go_to(c2 + BLANK + 2 + DEAD + OFF + BLANK + 1);

        // Brake suppresses chopping; release re-blanks
        c = cyc;
        brake_i = 1'b1; trip_i = 1'b1;
        push_quiet(c + 1, c + 20, "R9");
        go_to(c + 20);
        brake_i = 1'b0;
        push_quiet(c + 21, c + 25, "R8");
        push_chop(c + 26);
        go_to(c + 26 + DEAD + OFF - 1);
        trip_i = 1'b0;
        go_to(c + 26 + DEAD + OFF + BLANK + 1);

        repeat (2) @(negedge clk);
        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R3 queue left %0d expected 0", q.size());
        end
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule